// File: doc/BRIEF.md
# Carry-Increment Adder

A purely combinational adder of parameterizable width that takes two operands and a carry-in, and returns their sum and a carry-out. The bit positions are split into consecutive groups. Bitwise generate and propagate terms are formed once for the whole word. Each group then computes its own prefix generate and propagate terms, as though no carry entered it. A single increment stage per group later folds in the real carry arriving at the group, so the precomputed local carries become true carries. The final sum XOR is also shared across the word.

This is the carry-select approach in a leaner form. Instead of building two complete group sums and choosing one once the late carry arrives, the block keeps one local carry chain per group and corrects it. The carry out of each group drives the next group, and the last group's carry is the adder carry-out. Groups can be uniform, with every group `GRP` bits wide. They can also grow, with group g holding `GRP + g` bits, which shortens the path for the carries that arrive later.

Top module: `cia_adder`

## Requirements
- R1: For every input, `{cout_o, sum_o}` equals the arithmetic value `a_i + b_i + cin_i`, taken `WIDTH+1` bits wide.
- R2: `cout_o` is the carry out of the most significant bit position, i.e. bit `WIDTH` of the R1 result. It is 1 exactly when the unsigned sum overflows `WIDTH` bits.
- R3: Inside a group, a bit position never both generates and propagates. When a group's local propagate over all its bits is 1, its local generate over those bits is 0.
- R4: A group whose bits all propagate passes its incoming carry through unchanged to its outgoing carry.
- R5: When `a_i` is the bitwise complement of `b_i` (all bits propagate), `sum_o` is all ones and `cout_o` is 0 for `cin_i = 0`. For `cin_i = 1`, `sum_o` is all zeros and `cout_o` is 1.
- R6: With both operands zero and `cin_i = 0`, `sum_o` and `cout_o` are 0. With both operands all ones and `cin_i = 1`, `sum_o` is all ones and `cout_o` is 1.
- R7: Setting `VARIABLE = 1` makes group g `GRP + g` bits wide, with the last group cut at `WIDTH`. The results are the same as in R1.
- R8: A carry produced in the lowest bit travels across a run of propagating bits that spans group boundaries. It lands on the first bit that does not propagate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach is a carry that must cross every group through the increment stages. This only happens when long runs of bits all propagate, and random operands almost never produce that. The stimulus therefore builds operand pairs that are exact complements, or complements above a chosen bit, with a generating pair placed at or below that bit. This forces the carry to ripple across several group boundaries to a known stopping point. Each pattern runs on a uniform-group instance and a growing-group instance.

// File: rtl/cia_pkg.sv
package cia_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } pg_t;

    function automatic int grp_start(input int g, input int n, input bit grow);
        if (grow) return g * n + (g * (g - 1)) / 2;
        return g * n;
    endfunction

    function automatic int grp_count(input int w, input int n, input bit grow);
        int c;
        c = 0;
        while (grp_start(c, n, grow) < w) c++;
        return c;
    endfunction

    function automatic int grp_len(input int g, input int w, input int n, input bit grow);
        int s;
        int l;
        s = grp_start(g, n, grow);
        l = grow ? n + g : n;
        if (s + l > w) l = w - s;
        return l;
    endfunction

endpackage

// File: rtl/cia_pg.sv
module cia_pg #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] prop_o
);
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            gen_o[i]  = a_i[i] & b_i[i];
            prop_o[i] = a_i[i] ^ b_i[i];
        end
    end
endmodule

// File: rtl/cia_group.sv
module cia_group #(
    parameter int LEN = 4
) (
    input  logic [LEN-1:0] gen_i,
    input  logic [LEN-1:0] prop_i,
    output logic [LEN-1:0] lgen_o,
    output logic [LEN-1:0] lprop_o
);
    import cia_pkg::*;

    pg_t pre_d [LEN];

    always_comb begin
        pre_d[0].g = gen_i[0];
        pre_d[0].p = prop_i[0];
        for (int i = 1; i < LEN; i++) begin
            pre_d[i].g = gen_i[i] | (prop_i[i] & pre_d[i-1].g);
            pre_d[i].p = prop_i[i] & pre_d[i-1].p;
        end
        for (int i = 0; i < LEN; i++) begin
            lgen_o[i]  = pre_d[i].g;
            lprop_o[i] = pre_d[i].p;
        end
    end

    // R3: a span that propagates throughout cannot also generate
    always_comb begin
        a_r3_no_gen_when_prop: assert (!(lprop_o[LEN-1] && lgen_o[LEN-1]))
            else $error("R3 violated: group both generates and propagates");
    end
endmodule

// File: rtl/cia_incr.sv
module cia_incr #(
    parameter int LEN = 4
) (
    input  logic [LEN-1:0] lgen_i,
    input  logic [LEN-1:0] lprop_i,
    input  logic           cin_i,
    output logic [LEN-1:0] carry_o,
    output logic           cout_o
);
    logic [LEN:0] c_d;

    always_comb begin
        c_d[0] = cin_i;
        for (int i = 0; i < LEN; i++)
            c_d[i+1] = lgen_i[i] | (lprop_i[i] & cin_i);
        carry_o = c_d[LEN-1:0];
        cout_o  = c_d[LEN];
    end

    // R4: a fully propagating group hands its carry-in straight through
    always_comb begin
        if (lprop_i[LEN-1])
            a_r4_pass_through: assert (cout_o == cin_i)
                else $error("R4 violated: propagate group altered carry");
    end
endmodule

// File: rtl/cia_adder.sv
module cia_adder #(
    parameter int WIDTH    = 32,
    parameter int GRP      = 4,
    parameter bit VARIABLE = 1'b0
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    import cia_pkg::*;

    localparam int NGRP = grp_count(WIDTH, GRP, VARIABLE);

    logic [WIDTH-1:0] gen_d;
    logic [WIDTH-1:0] prop_d;
    logic [WIDTH-1:0] carry_d;
    logic [NGRP:0]    gcarry_d;

    cia_pg #(.WIDTH(WIDTH)) u_pg (
        .a_i    (a_i),
        .b_i    (b_i),
        .gen_o  (gen_d),
        .prop_o (prop_d)
    );

    assign gcarry_d[0] = cin_i;

    for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
        localparam int ST  = grp_start(gi, GRP, VARIABLE);
        localparam int LEN = grp_len(gi, WIDTH, GRP, VARIABLE);

        logic [LEN-1:0] lgen_d;
        logic [LEN-1:0] lprop_d;
        logic [LEN-1:0] c_d;

        cia_group #(.LEN(LEN)) u_grp (
            .gen_i   (gen_d[ST +: LEN]),
            .prop_i  (prop_d[ST +: LEN]),
            .lgen_o  (lgen_d),
            .lprop_o (lprop_d)
        );

        cia_incr #(.LEN(LEN)) u_inc (
            .lgen_i  (lgen_d),
            .lprop_i (lprop_d),
            .cin_i   (gcarry_d[gi]),
            .carry_o (c_d),
            .cout_o  (gcarry_d[gi+1])
        );

        assign carry_d[ST +: LEN] = c_d;
    end

    always_comb begin
        sum_o  = prop_d ^ carry_d;
        cout_o = gcarry_d[NGRP];
    end

    logic [WIDTH:0] ref_d;
    assign ref_d = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    always_comb begin
        a_r1_sum_matches: assert ({cout_o, sum_o} == ref_d)
            else $error("R1 violated: sum mismatch");
        if ((a_i ^ b_i) == {WIDTH{1'b1}})
            a_r5_full_propagate: assert (cout_o == cin_i && sum_o == {WIDTH{~cin_i}})
                else $error("R5 violated: full propagate result");
    end
endmodule

// File: tb/tb_cia_adder.sv
module tb_cia_adder;
    localparam int W = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] a, b;
    logic         cin;
    logic [W-1:0] s_u, s_v;
    logic         co_u, co_v;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    cia_adder #(.WIDTH(W), .GRP(4), .VARIABLE(1'b0)) dut (
        .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s_u), .cout_o(co_u));

    cia_adder #(.WIDTH(W), .GRP(2), .VARIABLE(1'b1)) dut_var (
        .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s_v), .cout_o(co_v));

    function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    task automatic chk(input string tag, input logic [W:0] act, input logic [W:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (a=%h b=%h cin=%0d)", tag, act, exp, a, b, cin);
        end
    endtask

    task automatic apply(input string tag, input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        @(negedge clk);
        a = x; b = y; cin = c;
        #1;
        chk({tag, " R1 uniform"}, {co_u, s_u}, model(x, y, c));
        chk({tag, " R7 variable"}, {co_v, s_v}, model(x, y, c));
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        a = '0; b = '0; cin = 1'b0;
        #1;
        // R6: zero state
        chk("R6 zero", {co_u, s_u}, '0);
        apply("R6 all ones", '1, '1, 1'b1);
        chk("R6 all ones", {co_u, s_u}, {1'b1, {W{1'b1}}});
        // R5: full propagate
        for (int k = 0; k < 8; k++) begin
            logic [W-1:0] x;
            x = $urandom;
            apply("R5 prop cin0", x, ~x, 1'b0);
            chk("R5 prop cin0", {co_u, s_u}, {1'b0, {W{1'b1}}});
            apply("R5 prop cin1", x, ~x, 1'b1);
            chk("R5 prop cin1", {co_v, s_v}, {1'b1, {W{1'b0}}});
        end
        // R8: generate at bit 0, propagate run up to bit t, kill at t
        for (int t = 1; t < W; t++) begin
            logic [W-1:0] x, y;
            x = $urandom; y = ~x;
            x[0] = 1'b1; y[0] = 1'b1;
            x[t] = 1'b0; y[t] = 1'b0;
            apply("R8 long run", x, y, 1'b0);
            chk("R8 landing bit", {32'd0, s_u[t]}, {32'd0, 1'b1});
        end
        // R2: overflow boundary
        apply("R2 max+1", '1, '0, 1'b1);
        chk("R2 cout set", {32'd0, co_u}, 33'd1);
        apply("R2 max no carry", '1, '0, 1'b0);
        chk("R2 cout clear", {32'd0, co_u}, 33'd0);
        // R3/R4 exercised through propagating groups plus random mix
        for (int k = 0; k < 3000; k++) begin
            logic [W-1:0] x, y;
            x = $urandom; y = $urandom;
            if (k % 5 == 0) y = ~x ^ (32'h1 << ($urandom % W));
            apply("R3 R4 random", x, y, 1'($urandom));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule